// File: doc/BRIEF.md
# Selective Pattern Scan Decompressor

This block turns a serial test stream into the data for one scan chain. The stream arrives one bit at a time under a valid/ready handshake. The first bit of every pattern is a mode flag. When the flag is clear, the bits that follow are copied to the scan output unchanged until one full pattern length has passed. When the flag is set, the pattern arrives as a short codeword for each segment. Each segment position has its own codeword width and its own dictionary. The block looks the codeword up, loads the rebuilt segment into a shift register and clocks it out one bit per cycle.

While a rebuilt segment is being clocked out, the block cannot take input, so the source sees ready held low. The segment count, segment width, codeword widths and dictionary contents are all parameters fixed at elaboration. The defaults describe a 40-bit pattern made of five 8-bit segments, which costs 8 codeword bits per pattern.

Top module: `selpat_decomp`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state that waits for a mode flag. It clears the pattern bit counter, holds `scan_valid` low and drives `in_ready` high.
- R2: An input bit is consumed only on a cycle where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low change nothing and produce no scan output.
- R3: The first bit consumed for a pattern is the mode flag: 0 selects raw pass-through and 1 selects codeword decoding. The flag itself never appears on the scan output.
- R4: In raw mode, each consumed bit appears on `scan_bit`, with `scan_valid` high, in the cycle after it is consumed, and in the order it arrived. The pattern ends after NUM_SEG*SEG_W bits (40 by default), and the next consumed bit is again a mode flag.
- R5: In decoding mode, segment i is preceded by its codeword, which is CW_WIDTHS[4i+3:4i] bits wide and sent most significant bit first. The default widths for segments 1 to 5 are 1, 2, 2, 1 and 2.
- R6: A codeword value v selects entry v of that segment's dictionary. The default entries, given in hex and indexed from 0, are: segment 1 {00, 21}, segment 2 {00, 14, 38, 08}, segment 3 {00, 8D, 8E}, segment 4 {00, B0}, segment 5 {00, C0, D0}.
- R7: A codeword value at or beyond the number of entries in that segment's dictionary decodes to an all-zero segment. By default this is value 3 in segments 3 and 5.
- R8: A decoded segment leaves on `scan_bit` most significant bit first, one bit per cycle, over SEG_W consecutive cycles. The first bit appears two cycles after the codeword's last bit is consumed. `in_ready` stays low for exactly SEG_W cycles from the cycle after that last bit, and input offered during that window is ignored.
- R9: After the last segment of a decoded pattern has been shifted out, the block returns to waiting for a mode flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial stream data bit |
| in_valid | input | 1 | Stream bit is offered |
| in_ready | output | 1 | Block can consume a stream bit this cycle |
| scan_bit | output | 1 | Scan chain data |
| scan_valid | output | 1 | `scan_bit` carries a scan bit this cycle |

## Verification
Several rules are checked by assertions on every cycle:
- the state after reset;
- that a mode flag never produces scan output;
- that a raw bit is echoed one cycle after it is consumed;
- that idle cycles in raw mode stay silent;
- that every cycle with ready low is followed by a scan output bit;
- that the bit counter and segment index stay in range.

Other behaviour only the directed scenarios can show:
- the actual bit patterns rebuilt from each dictionary;
- the all-zero result for unused codewords;
- the exact length of each stall window;
- that junk offered during a stall is not consumed;
- clean recovery from a reset in the middle of a pattern.

// File: rtl/selpat_pkg.sv
package selpat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAW   = 2'd1,
    ST_CODE  = 2'd2,
    ST_SHIFT = 2'd3
  } selpat_state_e;

  localparam int FIELD_W = 4;

endpackage

// File: rtl/selpat_ctrl.sv
module selpat_ctrl
  import selpat_pkg::*;
#(
  parameter int NUM_SEG = 5,
  parameter int SEG_W   = 8,
  parameter int CW_MAX  = 2,
  parameter logic [NUM_SEG*FIELD_W-1:0] CW_WIDTHS = '0,
  localparam int RAW_LEN = NUM_SEG * SEG_W,
  localparam int CNT_W   = $clog2(RAW_LEN),
  localparam int SEG_IW  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int BIT_W   = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_bit,
  input  logic                in_valid,
  output logic                in_ready,
  output selpat_state_e       state,
  output logic [CNT_W-1:0]    raw_cnt,
  output logic [SEG_IW-1:0]   seg_idx,
  output logic [CW_MAX-1:0]   code_next,
  output logic                load_seg,
  output logic                raw_fire,
  output logic                shift_en
);

  logic                 accept;
  logic [CW_MAX-1:0]    cw_reg;
  logic [FIELD_W-1:0]   cw_cnt;
  logic [FIELD_W-1:0]   cur_w;
  logic [BIT_W-1:0]     bit_cnt;
  logic                 cw_last;
  logic                 shift_last;
  logic                 raw_last;
  logic                 seg_last;
  logic [CW_MAX:0]      cw_ext;

  assign in_ready   = (state != ST_SHIFT);
  assign accept     = in_valid & in_ready;
  assign cur_w      = CW_WIDTHS[int'(seg_idx)*FIELD_W +: FIELD_W];
  assign cw_last    = (cw_cnt == cur_w - FIELD_W'(1));
  assign shift_last = (bit_cnt == BIT_W'(SEG_W - 1));
  assign raw_last   = (raw_cnt == CNT_W'(RAW_LEN - 1));
  assign seg_last   = (seg_idx == SEG_IW'(NUM_SEG - 1));
  assign cw_ext     = {cw_reg, in_bit};
  assign code_next  = cw_ext[CW_MAX-1:0];

  assign load_seg = (state == ST_CODE) & accept & cw_last;
  assign raw_fire = (state == ST_RAW) & accept;
  assign shift_en = (state == ST_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      raw_cnt <= '0;
      seg_idx <= '0;
      cw_reg  <= '0;
      cw_cnt  <= '0;
      bit_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            raw_cnt <= '0;
            seg_idx <= '0;
            cw_reg  <= '0;
            cw_cnt  <= '0;
            state   <= in_bit ? ST_CODE : ST_RAW;
          end
        end
        ST_RAW: begin
          if (accept) begin
            if (raw_last) begin
              raw_cnt <= '0;
              state   <= ST_IDLE;
            end else begin
              raw_cnt <= raw_cnt + CNT_W'(1);
            end
          end
        end
        ST_CODE: begin
          if (accept) begin
            cw_reg <= code_next;
            if (cw_last) begin
              cw_cnt  <= '0;
              bit_cnt <= '0;
              state   <= ST_SHIFT;
            end else begin
              cw_cnt <= cw_cnt + FIELD_W'(1);
            end
          end
        end
        ST_SHIFT: begin
          if (shift_last) begin
            bit_cnt <= '0;
            cw_reg  <= '0;
            if (seg_last) begin
              seg_idx <= '0;
              state   <= ST_IDLE;
            end else begin
              seg_idx <= seg_idx + SEG_IW'(1);
              state   <= ST_CODE;
            end
          end else begin
            bit_cnt <= bit_cnt + BIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/selpat_dict.sv
module selpat_dict
  import selpat_pkg::*;
#(
  parameter int NUM_SEG = 5,
  parameter int SEG_W   = 8,
  parameter int CW_MAX  = 2,
  localparam int DEPTH  = 1 << CW_MAX,
  localparam int SEG_IW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  parameter logic [NUM_SEG*DEPTH*SEG_W-1:0] DICT     = '0,
  parameter logic [NUM_SEG*FIELD_W-1:0]     DICT_CNT = '0
) (
  input  logic [SEG_IW-1:0]  seg_idx,
  input  logic [CW_MAX-1:0]  code,
  output logic [SEG_W-1:0]   pattern
);

  logic [SEG_W-1:0] seg_pat [NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int CNT = int'(DICT_CNT[s*FIELD_W +: FIELD_W]);
    logic [SEG_W-1:0] entry;
    assign entry = DICT[(s*DEPTH + int'(code))*SEG_W +: SEG_W];
    assign seg_pat[s] = (int'(code) < CNT) ? entry : '0;
  end

  always_comb begin
    pattern = '0;
    if (int'(seg_idx) < NUM_SEG) pattern = seg_pat[seg_idx];
  end

endmodule

// File: rtl/selpat_shreg.sv
module selpat_shreg #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEG_W-1:0] load_val,
  input  logic             shift,
  output logic             msb
);

  logic [SEG_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= load_val;
    else if (shift) sr <= {sr[SEG_W-2:0], 1'b0};
  end

  assign msb = sr[SEG_W-1];

endmodule

// File: rtl/selpat_decomp.sv
module selpat_decomp
  import selpat_pkg::*;
#(
  parameter int NUM_SEG = 5,
  parameter int SEG_W   = 8,
  parameter int CW_MAX  = 2,
  parameter logic [NUM_SEG*FIELD_W-1:0] CW_WIDTHS = {4'd2, 4'd1, 4'd2, 4'd2, 4'd1},
  parameter logic [NUM_SEG*FIELD_W-1:0] DICT_CNT  = {4'd3, 4'd2, 4'd3, 4'd4, 4'd2},
  parameter logic [NUM_SEG*(1<<CW_MAX)*SEG_W-1:0] DICT =
    160'h00D0C000_0000B000_008E8D00_08381400_00002100
) (
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  output logic scan_bit,
  output logic scan_valid
);

  localparam int RAW_LEN = NUM_SEG * SEG_W;
  localparam int CNT_W   = $clog2(RAW_LEN);
  localparam int SEG_IW  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  selpat_state_e      state;
  logic [CNT_W-1:0]   raw_cnt;
  logic [SEG_IW-1:0]  seg_idx;
  logic [CW_MAX-1:0]  code_next;
  logic               load_seg;
  logic               raw_fire;
  logic               shift_en;
  logic [SEG_W-1:0]   seg_pattern;
  logic               sr_msb;

  selpat_ctrl #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .CW_MAX(CW_MAX), .CW_WIDTHS(CW_WIDTHS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .in_ready(in_ready), .state(state), .raw_cnt(raw_cnt), .seg_idx(seg_idx),
    .code_next(code_next), .load_seg(load_seg), .raw_fire(raw_fire),
    .shift_en(shift_en)
  );

  selpat_dict #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .CW_MAX(CW_MAX),
    .DICT(DICT), .DICT_CNT(DICT_CNT)
  ) u_dict (
    .seg_idx(seg_idx), .code(code_next), .pattern(seg_pattern)
  );

  selpat_shreg #(.SEG_W(SEG_W)) u_shreg (
    .clk(clk), .rst(rst), .load(load_seg), .load_val(seg_pattern),
    .shift(shift_en), .msb(sr_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_valid <= 1'b0;
      scan_bit   <= 1'b0;
    end else begin
      scan_valid <= raw_fire | shift_en;
      scan_bit   <= raw_fire ? in_bit : (shift_en & sr_msb);
    end
  end

endmodule

// File: rtl/selpat_decomp_chk.sv
module selpat_decomp_chk
  import selpat_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int SEG_IW  = 3,
  parameter int RAW_LEN = 40,
  parameter int NUM_SEG = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_bit,
  input logic              in_valid,
  input logic              in_ready,
  input logic              scan_bit,
  input logic              scan_valid,
  input selpat_state_e     state,
  input logic [CNT_W-1:0]  raw_cnt,
  input logic [SEG_IW-1:0] seg_idx
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (in_ready && !scan_valid));

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RAW && !in_valid) |=> !scan_valid);

  a_r3_flag_silent: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && in_valid && in_ready) |=> !scan_valid);

  a_r4_raw_echo: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RAW && in_valid && in_ready) |=> (scan_valid && scan_bit == $past(in_bit)));

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    int'(raw_cnt) < RAW_LEN);

  a_r8_stall_emits: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> scan_valid);

  a_r9_seg_range: assert property (@(posedge clk) disable iff (rst)
    int'(seg_idx) < NUM_SEG);

endmodule

bind selpat_decomp selpat_decomp_chk #(
  .CNT_W(CNT_W), .SEG_IW(SEG_IW), .RAW_LEN(RAW_LEN), .NUM_SEG(NUM_SEG)
) u_chk (
  .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
  .in_ready(in_ready), .scan_bit(scan_bit), .scan_valid(scan_valid),
  .state(state), .raw_cnt(raw_cnt), .seg_idx(seg_idx)
);

// File: tb/selpat_decomp_bench.sv
`timescale 1ns/1ps
module selpat_decomp_bench;

  localparam int NSEG = 5;
  localparam int SW   = 8;
  localparam int PLEN = NSEG * SW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic scan_bit;
  logic scan_valid;

  int checks = 0;
  int fails = 0;
  logic out_buf [0:127];
  int out_n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  selpat_decomp u_selpat_decomp (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .in_ready(in_ready), .scan_bit(scan_bit), .scan_valid(scan_valid)
  );

  always @(posedge clk) begin
    #1;
    if (scan_valid && out_n < 128) begin
      out_buf[out_n] = scan_bit;
      out_n++;
    end
  end

  function automatic int cw_width(int s);
    int w [NSEG] = '{1, 2, 2, 1, 2};
    return w[s];
  endfunction

  function automatic logic [7:0] ref_entry(int s, int e);
    case (s)
      0: return (e == 1) ? 8'h21 : 8'h00;
      1: return (e == 1) ? 8'h14 : (e == 2) ? 8'h38 : (e == 3) ? 8'h08 : 8'h00;
      2: return (e == 1) ? 8'h8D : (e == 2) ? 8'h8E : 8'h00;
      3: return (e == 1) ? 8'hB0 : 8'h00;
      default: return (e == 1) ? 8'hC0 : (e == 2) ? 8'hD0 : 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [PLEN-1:0] collected();
    logic [PLEN-1:0] v = '0;
    for (int j = 0; j < PLEN; j++) v[PLEN-1-j] = out_buf[j];
    return v;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
    check(scan_valid === 1'b0, "R1 scan_valid after reset", 64'(scan_valid), 64'd0);
    rst = 1'b0;
    out_n = 0;
  endtask

  task automatic t_raw(input logic [PLEN-1:0] vec, input bit gaps);
    out_n = 0;
    send_bit(1'b0);
    for (int i = PLEN - 1; i >= 0; i--) begin
      send_bit(vec[i]);
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk);
        @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    check(out_n == PLEN, gaps ? "R2 raw count with idle gaps" : "R4 raw count", 64'(out_n), 64'(PLEN));
    check(collected() == vec, gaps ? "R2 raw data with idle gaps" : "R4 raw data", 64'(collected()), 64'(vec));
    check(in_ready === 1'b1, "R4 ready after raw pattern", 64'(in_ready), 64'd1);
  endtask

  task automatic t_comp(input int c0, input int c1, input int c2, input int c3, input int c4,
                        input bit noisy, input string tag);
    int codes [NSEG];
    logic [PLEN-1:0] exp;
    codes = '{c0, c1, c2, c3, c4};
    exp = '0;
    out_n = 0;
    send_bit(1'b1);
    for (int s = 0; s < NSEG; s++) begin
      int w;
      int lows;
      w = cw_width(s);
      exp[PLEN-1-s*SW -: SW] = ref_entry(s, codes[s]);
      for (int b = w - 1; b >= 0; b--) send_bit(1'((codes[s] >> b) & 1));
      lows = 0;
      while (!in_ready) begin
        in_valid = noisy;
        in_bit = 1'b1;
        lows++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check(lows == SW, "R8 stall length", 64'(lows), 64'(SW));
    end
    repeat (3) @(negedge clk);
    check(out_n == PLEN, {tag, " count"}, 64'(out_n), 64'(PLEN));
    check(collected() == exp, tag, 64'(collected()), 64'(exp));
    check(in_ready === 1'b1, "R9 back to idle after decoded pattern", 64'(in_ready), 64'd1);
  endtask

  task automatic t_mid_reset();
    out_n = 0;
    send_bit(1'b0);
    for (int i = 0; i < 11; i++) send_bit(1'(i & 1));
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after mid-pattern reset", 64'(in_ready), 64'd1);
    check(scan_valid === 1'b0, "R1 no output after mid-pattern reset", 64'(scan_valid), 64'd0);
    rst = 1'b0;
    t_comp(1, 2, 1, 1, 2, 1'b0, "R3 flag after reset selects decoding");
    t_raw(40'hF0_0F_A5_5A_C3, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_raw(40'h96_3C_E1_0F_5B, 1'b0);
    t_raw(40'h12_34_56_78_9A, 1'b1);
    t_comp(1, 3, 2, 1, 2, 1'b0, "R6 decode top entries");
    t_comp(0, 0, 0, 0, 0, 1'b0, "R5 all zero codewords");
    t_comp(1, 1, 3, 1, 3, 1'b0, "R7 unused codewords give zeros");
    t_comp(0, 2, 1, 0, 1, 1'b1, "R8 input held during stall ignored");
    t_raw(40'hAA_55_00_FF_81, 1'b0);
    t_mid_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule